// File: doc/BRIEF.md
# Pipeline Register File with Same-Cycle Write Forwarding

This block is the architectural register store of a five-stage in-order pipeline. It holds eight general registers of a configurable width. The decode stage reads two operands through two combinational read ports. The writeback stage updates one register per cycle through a single synchronous write port.

A decode-stage read and a writeback-stage write often name the same register in the same cycle. For that case the read port returns the data being written rather than the stale stored value. The visible result is the same as if the write happened in the first half of the cycle and the read in the second half. The block still uses only one rising clock edge and a combinational selection path.

Register 0 is a constant zero. Writes aimed at it are dropped, and they are never forwarded to a read port.

Top module: `wb_regfile`

## Requirements
- R1: After the asynchronous active-low reset is released, every register reads as zero on both read ports.
- R2: A write with `wr_en` high to a nonzero address is stored at the rising clock edge. From the next cycle on, both read ports return the written value for that address.
- R3: When `wr_en` is high, `wr_addr` is nonzero and a read address equals `wr_addr`, that read port returns `wr_data` in the same cycle, before the clock edge.
- R4: Address 0 always reads as zero. A write to address 0 is neither stored nor forwarded, even while `wr_en` is high.
- R5: While `wr_en` is low, no register changes and no forwarding takes place, whatever `wr_addr` and `wr_data` hold.
- R6: Each read port decides on forwarding independently. A port whose address differs from `wr_addr` returns its stored value. Two ports that read the same address always return equal data.
- R7: A write changes only the addressed register. All other registers keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset; clears all registers |
| wr_en | input | 1 | Writeback stage is writing a register |
| wr_addr | input | $clog2(NUM_REGS) | Destination register of the write |
| wr_data | input | WIDTH | Value being written |
| rd_a_addr | input | $clog2(NUM_REGS) | First operand register address |
| rd_a_data | output | WIDTH | First operand value (combinational) |
| rd_b_addr | input | $clog2(NUM_REGS) | Second operand register address |
| rd_b_data | output | WIDTH | Second operand value (combinational) |

## Verification
A corrupted stored entry stays hidden until an address selects it. Because the read path is combinational, the bad value then shows on the read port in that same cycle. A missing or wrong forwarding comparison shows up only while a write and a read name the same register together. The bench therefore probes that window before the clock edge, and probes it again after the edge to confirm the value was stored. Address 0 and disabled writes are checked both in the cycle of the attempt and in the cycle after it, since a leak through storage appears one cycle later than a leak through forwarding.

// File: rtl/regfile_pkg.sv
package regfile_pkg;

    // Source chosen by a read port for its output value.
    typedef enum logic [1:0] {
        SRC_ZERO   = 2'd0,
        SRC_STORED = 2'd1,
        SRC_WRITE  = 2'd2
    } rd_src_e;

    // Forwarding decision shared by every read port.
    function automatic rd_src_e pick_source(input logic rd_is_zero,
                                            input logic wr_live,
                                            input logic addr_match);
        if (rd_is_zero)
            return SRC_ZERO;
        else if (wr_live && addr_match)
            return SRC_WRITE;
        else
            return SRC_STORED;
    endfunction

endpackage

// File: rtl/rf_store.sv
module rf_store #(
    parameter int WIDTH    = 32,
    parameter int NUM_REGS = 8,
    localparam int AW      = $clog2(NUM_REGS)
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               wr_en,
    input  logic [AW-1:0]                      wr_addr,
    input  logic [WIDTH-1:0]                   wr_data,
    output logic [NUM_REGS-1:0][WIDTH-1:0]     regs_q
);

    typedef struct packed {
        logic [NUM_REGS-1:0][WIDTH-1:0] regs;
    } store_t;

    store_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en && (wr_addr != '0))
            st_d.regs[wr_addr] = wr_data;
        st_d.regs[0] = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign regs_q = st_q.regs;

endmodule

// File: rtl/rf_read_port.sv
module rf_read_port
    import regfile_pkg::*;
#(
    parameter int WIDTH    = 32,
    parameter int NUM_REGS = 8,
    localparam int AW      = $clog2(NUM_REGS)
) (
    input  logic [AW-1:0]                  rd_addr,
    input  logic [NUM_REGS-1:0][WIDTH-1:0] regs_q,
    input  logic                           wr_en,
    input  logic [AW-1:0]                  wr_addr,
    input  logic [WIDTH-1:0]               wr_data,
    output logic [WIDTH-1:0]               rd_data
);

    rd_src_e src;

    always_comb begin
        src = pick_source(rd_addr == '0, wr_en, rd_addr == wr_addr);
        unique case (src)
            SRC_WRITE:  rd_data = wr_data;
            SRC_STORED: rd_data = regs_q[rd_addr];
            default:    rd_data = '0;
        endcase
    end

endmodule

// File: rtl/wb_regfile.sv
module wb_regfile #(
    parameter int WIDTH    = 32,
    parameter int NUM_REGS = 8,
    localparam int AW      = $clog2(NUM_REGS),
    localparam int NPORTS  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [AW-1:0]    wr_addr,
    input  logic [WIDTH-1:0] wr_data,
    input  logic [AW-1:0]    rd_a_addr,
    output logic [WIDTH-1:0] rd_a_data,
    input  logic [AW-1:0]    rd_b_addr,
    output logic [WIDTH-1:0] rd_b_data
);

    logic [NUM_REGS-1:0][WIDTH-1:0] regs_q;
    logic [NPORTS-1:0][AW-1:0]      rd_addr_v;
    logic [NPORTS-1:0][WIDTH-1:0]   rd_data_v;

    assign rd_addr_v[0] = rd_a_addr;
    assign rd_addr_v[1] = rd_b_addr;
    assign rd_a_data    = rd_data_v[0];
    assign rd_b_data    = rd_data_v[1];

    rf_store #(.WIDTH(WIDTH), .NUM_REGS(NUM_REGS)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .regs_q  (regs_q)
    );

    for (genvar p = 0; p < NPORTS; p++) begin : g_rd
        rf_read_port #(.WIDTH(WIDTH), .NUM_REGS(NUM_REGS)) u_port (
            .rd_addr (rd_addr_v[p]),
            .regs_q  (regs_q),
            .wr_en   (wr_en),
            .wr_addr (wr_addr),
            .wr_data (wr_data),
            .rd_data (rd_data_v[p])
        );
    end

endmodule

// File: rtl/wb_regfile_checker.sv
module wb_regfile_checker #(
    parameter int WIDTH    = 32,
    parameter int NUM_REGS = 8,
    localparam int AW      = $clog2(NUM_REGS)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic [AW-1:0]    wr_addr,
    input logic [WIDTH-1:0] wr_data,
    input logic [AW-1:0]    rd_a_addr,
    input logic [WIDTH-1:0] rd_a_data,
    input logic [AW-1:0]    rd_b_addr,
    input logic [WIDTH-1:0] rd_b_data
);

    assert_zero_a_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_a_addr == '0) |-> (rd_a_data == '0));

    assert_zero_b_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_b_addr == '0) |-> (rd_b_data == '0));

    assert_fwd_a_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr != '0 && rd_a_addr == wr_addr) |-> (rd_a_data == wr_data));

    assert_fwd_b_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr != '0 && rd_b_addr == wr_addr) |-> (rd_b_data == wr_data));

    assert_stored_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr != '0) |=>
        ((rd_a_addr == $past(wr_addr) && !(wr_en && wr_addr == rd_a_addr))
            ? (rd_a_data == $past(wr_data)) : 1'b1));

    assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en) |=>
        ((rd_a_addr == $past(rd_a_addr) && !(wr_en && wr_addr == rd_a_addr))
            ? (rd_a_data == $past(rd_a_data)) : 1'b1));

    assert_ports_agree_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_a_addr == rd_b_addr) |-> (rd_a_data == rd_b_data));

endmodule

bind wb_regfile wb_regfile_checker #(.WIDTH(WIDTH), .NUM_REGS(NUM_REGS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .rd_a_addr (rd_a_addr),
    .rd_a_data (rd_a_data),
    .rd_b_addr (rd_b_addr),
    .rd_b_data (rd_b_data)
);

// File: tb/wb_regfile_tb.sv
module wb_regfile_tb;

    localparam int WIDTH    = 32;
    localparam int NUM_REGS = 8;
    localparam int AW       = $clog2(NUM_REGS);

    logic             clk = 1'b0;
    logic             rst_n;
    logic             wr_en;
    logic [AW-1:0]    wr_addr;
    logic [WIDTH-1:0] wr_data;
    logic [AW-1:0]    rd_a_addr;
    logic [WIDTH-1:0] rd_a_data;
    logic [AW-1:0]    rd_b_addr;
    logic [WIDTH-1:0] rd_b_data;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    logic [WIDTH-1:0] model [NUM_REGS];

    always #5 clk = ~clk;

    wb_regfile #(.WIDTH(WIDTH), .NUM_REGS(NUM_REGS)) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_a_addr(rd_a_addr), .rd_a_data(rd_a_data),
        .rd_b_addr(rd_b_addr), .rd_b_data(rd_b_data)
    );

    task automatic check(input string req, input logic [WIDTH-1:0] got,
                         input logic [WIDTH-1:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    // Drive a cycle's inputs just after the falling edge; outputs settle 1 ns later.
    task automatic drive(input logic we, input logic [AW-1:0] wa,
                         input logic [WIDTH-1:0] wd,
                         input logic [AW-1:0] ra, input logic [AW-1:0] rb);
        @(negedge clk);
        wr_en = we; wr_addr = wa; wr_data = wd;
        rd_a_addr = ra; rd_b_addr = rb;
        #1;
    endtask

    task automatic write_reg(input logic [AW-1:0] a, input logic [WIDTH-1:0] d);
        drive(1'b1, a, d, '0, '0);
        if (a != '0) model[a] = d;
    endtask

    task automatic t_reset_r1;
        for (int i = 0; i < NUM_REGS; i++) begin
            drive(1'b0, '0, '0, AW'(i), AW'(NUM_REGS - 1 - i));
            check("R1 port A after reset", rd_a_data, '0);
            check("R1 port B after reset", rd_b_data, '0);
        end
    endtask

    task automatic t_write_then_read_r2;
        write_reg(3'd3, 32'hDEAD_BEEF);
        drive(1'b0, '0, '0, 3'd3, 3'd3);
        check("R2 port A stored value", rd_a_data, 32'hDEAD_BEEF);
        check("R2 port B stored value", rd_b_data, 32'hDEAD_BEEF);
    endtask

    task automatic t_forward_r3;
        drive(1'b1, 3'd5, 32'h1234_5678, 3'd5, 3'd5);
        check("R3 port A forwarded same cycle", rd_a_data, 32'h1234_5678);
        check("R3 port B forwarded same cycle", rd_b_data, 32'h1234_5678);
        model[5] = 32'h1234_5678;
        drive(1'b0, '0, '0, 3'd5, 3'd1);
        check("R3 forwarded value also stored", rd_a_data, 32'h1234_5678);
        // highest address forwarded on port B only
        drive(1'b1, 3'd7, 32'hFFFF_0001, 3'd1, 3'd7);
        check("R3 port B forward at top address", rd_b_data, 32'hFFFF_0001);
        model[7] = 32'hFFFF_0001;
    endtask

    task automatic t_zero_reg_r4;
        drive(1'b1, 3'd0, 32'hAAAA_5555, 3'd0, 3'd0);
        check("R4 write to reg 0 not forwarded A", rd_a_data, '0);
        check("R4 write to reg 0 not forwarded B", rd_b_data, '0);
        drive(1'b0, '0, '0, 3'd0, 3'd0);
        check("R4 write to reg 0 not stored", rd_a_data, '0);
    endtask

    task automatic t_disabled_r5;
        drive(1'b0, 3'd3, 32'h0BAD_0BAD, 3'd3, 3'd3);
        check("R5 no forwarding while disabled", rd_a_data, model[3]);
        drive(1'b0, '0, '0, 3'd3, 3'd3);
        check("R5 no store while disabled", rd_b_data, model[3]);
    endtask

    task automatic t_independent_r6;
        write_reg(3'd2, 32'h2222_2222);
        drive(1'b1, 3'd6, 32'h6666_6666, 3'd6, 3'd2);
        check("R6 port A forwards", rd_a_data, 32'h6666_6666);
        check("R6 port B unaffected", rd_b_data, 32'h2222_2222);
        model[6] = 32'h6666_6666;
        drive(1'b1, 3'd4, 32'h4444_4444, 3'd2, 3'd4);
        check("R6 port A unaffected", rd_a_data, 32'h2222_2222);
        check("R6 port B forwards", rd_b_data, 32'h4444_4444);
        model[4] = 32'h4444_4444;
    endtask

    task automatic t_retain_r7;
        write_reg(3'd1, 32'h0000_0011);
        write_reg(3'd1, 32'h0000_0022);
        for (int i = 0; i < NUM_REGS; i++) begin
            drive(1'b0, '0, '0, AW'(i), AW'(i));
            check("R7 register contents", rd_a_data, (i == 0) ? '0 : model[i]);
        end
    endtask

    initial begin
        for (int i = 0; i < NUM_REGS; i++) model[i] = '0;
        rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
        rd_a_addr = '0; rd_b_addr = '0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        t_reset_r1();
        t_write_then_read_r2();
        t_forward_r3();
        t_zero_reg_r4();
        t_disabled_r5();
        t_independent_r6();
        t_retain_r7();
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        #100000;
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule